// File: doc/BRIEF.md
# Serial Receiver with Terminating-Character Detection

This block is the receive side of an asynchronous serial port, seen from a processor or a DMA-style master through a small register window. A state machine watches the serial line and takes bit timing from a programmable divisor. It samples the start bit at mid-bit, shifts data bits in LSB first, and checks the stop bit. Each finished character is placed in a holding register, and a data-available signal rises to show that it is there.

Every character that arrives is compared with a programmable terminating character. On a match the block sets a sticky end-of-packet status flag. The flag can raise the interrupt. An end-of-packet sideband output is also driven for as long as the matching character waits to be read. This lets a flow-controlled master copy characters into memory and stop on the terminator. A build parameter removes the comparison logic. In that build the terminator slot reads as zero and ignores writes.

The receive state machine has four states. IDLE waits for a low line and goes to START. START waits half a bit time. If the line is still low it goes to DATA; if not, it drops back to IDLE as a false start. DATA samples one bit every bit time, and after the last data bit it goes to STOP. STOP samples the stop bit, reports the character as good or framing-bad, and returns to IDLE.

Top module: `uart_rx_eop`

## Requirements
- R1: After reset the status word is 0, data_avail, irq and eop_out are low, the divisor reads DIV_RESET and the terminator reads 0.
- R2: A frame has a low start bit, DATA_BITS data bits sent LSB first and a high stop bit, each lasting `divisor` clock cycles. The block receives the frame, places the character at offset 0 and raises data_avail.
- R3: A read strobe (rd_en) at offset 0 clears data_avail on the next cycle, unless a new character completes in that same cycle.
- R4: A stop bit sampled low sets the frame-error flag (status bit 2) and discards the character, so data_avail does not rise.
- R5: A character that completes while data_avail is high sets the overrun flag (status bit 1) and replaces the held character.
- R6: When a received character equals the terminator register (offset 5, DATA_BITS wide), the end-of-packet flag (status bit 3) is set. The flag stays set after the character is read.
- R7: Any write to the status register (offset 2) clears status bits 1, 2 and 3. Status bit 0 mirrors data_avail and is read-only.
- R8: eop_out is high exactly while data_avail is high and the held character matched the terminator when it was received.
- R9: irq is the OR over status bits 0 to 3 of each bit ANDed with the same bit of the control register (offset 3).
- R10: The divisor is written at offset 4. A written value below 2 is stored as 2.
- R11: With EOP_EN=0, writes to offset 5 are ignored, offset 5 reads 0, status bit 3 never sets and eop_out stays low.
- R12: If the line is high again when the start bit is sampled at mid-bit, the block returns to IDLE. No character is stored and no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive line, idle high |
| addr | input | ADDR_W | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (clears data_avail at offset 0) |
| wdata | input | BUS_W | Write data |
| rdata | output | BUS_W | Read data for addr, combinational |
| data_avail | output | 1 | Unread character held |
| eop_out | output | 1 | Held character is the terminator |
| irq | output | 1 | Interrupt request |

## Verification
A wrong bit count or a slipped sampling point in the receive state machine would show up as a wrong character at offset 0 within one frame. A mistimed sample near the end of the frame would instead set a false frame-error flag. A faulty comparison or a broken sticky flag would show in status bit 3 and in eop_out the first time a character arrives after the terminator is programmed. Sweeping every 8-bit character against one fixed terminator exposes both missed matches and false matches. Errors in flag priority, such as overrun versus read, or set versus clear, appear at the ports on the cycle after the colliding strobes.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_t;

    localparam int OFS_DATA    = 0;
    localparam int OFS_STATUS  = 2;
    localparam int OFS_CTRL    = 3;
    localparam int OFS_DIVISOR = 4;
    localparam int OFS_TERM    = 5;

    localparam int ST_AVAIL = 0;
    localparam int ST_OVR   = 1;
    localparam int ST_FERR  = 2;
    localparam int ST_EOP   = 3;
    localparam int ST_BITS  = 4;

endpackage

// File: rtl/rx_serial_fsm.sv
module rx_serial_fsm
    import uart_rx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int DIV_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rxd,
    input  logic [DIV_W-1:0]     divisor,
    output logic                 char_done,
    output logic                 frame_ok,
    output logic [DATA_BITS-1:0] char_data
);
    localparam int BCNT_W = $clog2(DATA_BITS + 1);

    rx_state_t            state_q, state_d;
    logic [1:0]           sync_q;
    logic                 rx_s;
    logic [DIV_W-1:0]     cnt_q;
    logic [BCNT_W-1:0]    bit_q;
    logic [DATA_BITS-1:0] shift_q;
    logic                 tick;
    logic                 last_bit;

    assign rx_s     = sync_q[1];
    assign tick     = (cnt_q == '0);
    assign last_bit = (bit_q == BCNT_W'(DATA_BITS - 1));

    // Two-flop synchronizer, idles high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rxd};
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (!rx_s) state_d = RX_START;
            RX_START: if (tick) state_d = rx_s ? RX_IDLE : RX_DATA;
            RX_DATA:  if (tick && last_bit) state_d = RX_STOP;
            RX_STOP:  if (tick) state_d = RX_IDLE;
            default:  state_d = RX_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // Counters, shifter and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            bit_q     <= '0;
            shift_q   <= '0;
            char_done <= 1'b0;
            frame_ok  <= 1'b0;
            char_data <= '0;
        end else begin
            char_done <= 1'b0;
            unique case (state_q)
                RX_IDLE: begin
                    cnt_q <= (divisor >> 1) - DIV_W'(1);
                    bit_q <= '0;
                end
                RX_START: begin
                    cnt_q <= tick ? divisor - DIV_W'(1) : cnt_q - DIV_W'(1);
                end
                RX_DATA: begin
                    if (tick) begin
                        shift_q <= {rx_s, shift_q[DATA_BITS-1:1]};
                        bit_q   <= bit_q + BCNT_W'(1);
                        cnt_q   <= divisor - DIV_W'(1);
                    end else begin
                        cnt_q <= cnt_q - DIV_W'(1);
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        char_done <= 1'b1;
                        frame_ok  <= rx_s;
                        char_data <= shift_q;
                    end else begin
                        cnt_q <= cnt_q - DIV_W'(1);
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    assert_bitcnt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_q <= BCNT_W'(DATA_BITS));

    assert_false_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_START && tick && rx_s) |=> (state_q == RX_IDLE && !char_done));

    assert_done_from_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        char_done |-> $past(state_q) == RX_STOP);

endmodule

// File: rtl/rx_term_match.sv
module rx_term_match #(
    parameter int  DATA_BITS = 8,
    parameter bit  EOP_EN    = 1'b1
) (
    input  logic [DATA_BITS-1:0] char_in,
    input  logic [DATA_BITS-1:0] term,
    output logic                 match
);
    generate
        if (EOP_EN) begin : g_cmp
            assign match = (char_in == term);
        end else begin : g_off
            assign match = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/rx_regs.sv
module rx_regs
    import uart_rx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int DIV_W     = 16,
    parameter int ADDR_W    = 3,
    parameter int BUS_W     = 16,
    parameter int DIV_RESET = 16,
    parameter bit EOP_EN    = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [BUS_W-1:0]     wdata,
    output logic [BUS_W-1:0]     rdata,
    input  logic                 char_done,
    input  logic                 frame_ok,
    input  logic [DATA_BITS-1:0] char_data,
    output logic [DIV_W-1:0]     divisor,
    output logic                 data_avail,
    output logic                 eop_out,
    output logic                 irq
);
    logic [DATA_BITS-1:0] hold_q;
    logic                 avail_q;
    logic                 hold_match_q;
    logic                 ovr_q, ferr_q, eop_q;
    logic [ST_BITS-1:0]   ctrl_q;
    logic [DIV_W-1:0]     div_q;
    logic [DATA_BITS-1:0] term_q;
    logic                 match;
    logic                 good_char;
    logic                 read_data;
    logic                 wr_status;
    logic [ST_BITS-1:0]   status;

    assign good_char = char_done && frame_ok;
    assign read_data = rd_en && (addr == ADDR_W'(OFS_DATA));
    assign wr_status = wr_en && (addr == ADDR_W'(OFS_STATUS));
    assign status    = {eop_q, ferr_q, ovr_q, avail_q};

    rx_term_match #(.DATA_BITS(DATA_BITS), .EOP_EN(EOP_EN)) u_match (
        .char_in (char_data),
        .term    (term_q),
        .match   (match)
    );

    generate
        if (EOP_EN) begin : g_term
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) term_q <= '0;
                else if (wr_en && addr == ADDR_W'(OFS_TERM))
                    term_q <= wdata[DATA_BITS-1:0];
            end
        end else begin : g_noterm
            assign term_q = '0;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q       <= '0;
            avail_q      <= 1'b0;
            hold_match_q <= 1'b0;
            ovr_q        <= 1'b0;
            ferr_q       <= 1'b0;
            eop_q        <= 1'b0;
            ctrl_q       <= '0;
            div_q        <= DIV_W'(DIV_RESET);
        end else begin
            if (wr_en && addr == ADDR_W'(OFS_CTRL))
                ctrl_q <= wdata[ST_BITS-1:0];
            if (wr_en && addr == ADDR_W'(OFS_DIVISOR))
                div_q <= (wdata[DIV_W-1:0] < DIV_W'(2)) ? DIV_W'(2) : wdata[DIV_W-1:0];
            if (wr_status) begin
                ovr_q  <= 1'b0;
                ferr_q <= 1'b0;
                eop_q  <= 1'b0;
            end
            if (read_data) avail_q <= 1'b0;
            if (char_done && !frame_ok) ferr_q <= 1'b1;
            if (good_char) begin
                hold_q       <= char_data;
                avail_q      <= 1'b1;
                hold_match_q <= match;
                if (avail_q && !read_data) ovr_q <= 1'b1;
                if (match) eop_q <= 1'b1;
            end
        end
    end

    assign divisor    = div_q;
    assign data_avail = avail_q;
    assign eop_out    = avail_q && hold_match_q;
    assign irq        = |(status & ctrl_q);

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_W'(OFS_DATA):    rdata = BUS_W'(hold_q);
            ADDR_W'(OFS_STATUS):  rdata = BUS_W'(status);
            ADDR_W'(OFS_CTRL):    rdata = BUS_W'(ctrl_q);
            ADDR_W'(OFS_DIVISOR): rdata = BUS_W'(div_q);
            ADDR_W'(OFS_TERM):    rdata = BUS_W'(term_q);
            default:              rdata = '0;
        endcase
    end

    assert_avail_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (read_data && !good_char) |=> !data_avail);

    assert_ferr_no_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (char_done && !frame_ok) |=> (ferr_q && $stable(hold_q)));

    assert_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (good_char && avail_q && !read_data) |=> ovr_q);

    assert_eop_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eop_q && !wr_status) |=> eop_q);

    assert_eop_needs_avail_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eop_out |-> data_avail);

    assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q == '0) |-> !irq);

    assert_div_min_R10: assert property (@(posedge clk) disable iff (!rst_n)
        divisor >= DIV_W'(2));

    generate
        if (!EOP_EN) begin : g_off_chk
            assert_eop_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
                !eop_out && !eop_q);
        end
    endgenerate

endmodule

// File: rtl/uart_rx_eop.sv
module uart_rx_eop
    import uart_rx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int DIV_W     = 16,
    parameter int ADDR_W    = 3,
    parameter int BUS_W     = 16,
    parameter int DIV_RESET = 16,
    parameter bit EOP_EN    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    output logic              data_avail,
    output logic              eop_out,
    output logic              irq
);
    logic                 char_done;
    logic                 frame_ok;
    logic [DATA_BITS-1:0] char_data;
    logic [DIV_W-1:0]     divisor;

    rx_serial_fsm #(.DATA_BITS(DATA_BITS), .DIV_W(DIV_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rxd       (rxd),
        .divisor   (divisor),
        .char_done (char_done),
        .frame_ok  (frame_ok),
        .char_data (char_data)
    );

    rx_regs #(
        .DATA_BITS (DATA_BITS),
        .DIV_W     (DIV_W),
        .ADDR_W    (ADDR_W),
        .BUS_W     (BUS_W),
        .DIV_RESET (DIV_RESET),
        .EOP_EN    (EOP_EN)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .wdata      (wdata),
        .rdata      (rdata),
        .char_done  (char_done),
        .frame_ok   (frame_ok),
        .char_data  (char_data),
        .divisor    (divisor),
        .data_avail (data_avail),
        .eop_out    (eop_out),
        .irq        (irq)
    );
endmodule

// File: tb/test_uart_rx_eop.sv
module test_uart_rx_eop;
    localparam int DB   = 8;
    localparam int AW   = 3;
    localparam int BW   = 16;
    localparam int DRST = 16;
    localparam int TERM = 8'h5A;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rxd = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [BW-1:0] wdata = '0;
    logic [BW-1:0] rdata, rdata_n;
    logic          avail, eop, irq, avail_n, eop_n, irq_n;

    int checks = 0;
    int errors = 0;
    int cur_div = DRST;

    always #10 clk = ~clk;

    uart_rx_eop #(.DATA_BITS(DB), .DIV_RESET(DRST), .EOP_EN(1'b1)) i_uart_rx_eop (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .addr(addr), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .data_avail(avail),
        .eop_out(eop), .irq(irq));

    uart_rx_eop #(.DATA_BITS(DB), .DIV_RESET(DRST), .EOP_EN(1'b0)) i_uart_rx_eop_noeop (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .addr(addr), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .rdata(rdata_n), .data_avail(avail_n),
        .eop_out(eop_n), .irq(irq_n));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input int a, input int d);
        @(negedge clk);
        addr = AW'(a); wdata = BW'(d); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input int a, input bit strobe, output logic [BW-1:0] d, output logic [BW-1:0] dn);
        @(negedge clk);
        addr = AW'(a); rd_en = strobe;
        #1;
        d = rdata; dn = rdata_n;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic send_char(input int ch, input bit stop);
        @(negedge clk);
        rxd = 1'b0;
        repeat (cur_div) @(negedge clk);
        for (int i = 0; i < DB; i++) begin
            rxd = ch[i];
            repeat (cur_div) @(negedge clk);
        end
        rxd = stop;
        repeat (cur_div) @(negedge clk);
        rxd = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [BW-1:0] d, dn;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 avail", avail, 0);
        check("R1 irq", irq, 0);
        check("R1 eop_out", eop, 0);
        bus_rd(2, 0, d, dn); check("R1 status", d, 0);
        bus_rd(4, 0, d, dn); check("R1 divisor", d, DRST);
        bus_rd(5, 0, d, dn); check("R1 term", d, 0);

        // R10 divisor clamp and programming
        bus_wr(4, 1);
        bus_rd(4, 0, d, dn); check("R10 clamp", d, 2);
        bus_wr(4, 8); cur_div = 8;
        bus_rd(4, 0, d, dn); check("R10 divisor", d, 8);

        // R11 no-EOP build ignores terminator writes
        bus_wr(5, TERM);
        bus_rd(5, 0, d, dn);
        check("R6 term readback", d, TERM);
        check("R11 term reads zero", dn, 0);

        // R2 R6 R8 full sweep of characters
        for (int ch = 0; ch < 256; ch++) begin
            bit m;
            m = (ch == TERM);
            send_char(ch, 1'b1);
            check("R2 avail", avail, 1);
            check("R8 eop_out", eop, m);
            check("R11 eop_out off", eop_n, 0);
            bus_rd(2, 0, d, dn);
            check("R6 status", d, m ? 32'h9 : 32'h1);
            check("R11 status", dn, 1);
            bus_rd(0, 1, d, dn);
            check("R2 data", d, ch);
            check("R3 avail cleared", avail, 0);
            check("R8 eop_out low after read", eop, 0);
            if (m) begin
                bus_rd(2, 0, d, dn); check("R6 sticky after read", d, 8);
                bus_wr(2, 0);
                bus_rd(2, 0, d, dn); check("R7 eop cleared", d, 0);
            end
        end

        // R4 frame error
        send_char(8'h33, 1'b0);
        check("R4 no store", avail, 0);
        bus_rd(2, 0, d, dn); check("R4 ferr", d, 4);
        bus_wr(2, 16'hFFFF);
        bus_rd(2, 0, d, dn); check("R7 ferr cleared", d, 0);

        // R5 overrun
        send_char(8'h11, 1'b1);
        send_char(8'hC4, 1'b1);
        bus_rd(2, 0, d, dn); check("R5 overrun", d, 3);
        bus_rd(0, 1, d, dn); check("R5 newer kept", d, 8'hC4);
        bus_wr(2, 0);

        // R12 false start
        @(negedge clk); rxd = 1'b0;
        repeat (2) @(negedge clk); rxd = 1'b1;
        repeat (12 * cur_div) @(negedge clk);
        check("R12 no char", avail, 0);
        bus_rd(2, 0, d, dn); check("R12 no flags", d, 0);

        // R9 interrupt masking
        bus_wr(3, 0);
        send_char(TERM, 1'b1);
        check("R9 masked", irq, 0);
        bus_wr(3, 1); check("R9 avail irq", irq, 1);
        bus_rd(0, 1, d, dn);
        check("R9 avail gone", irq, 0);
        bus_wr(3, 8); check("R9 eop irq", irq, 1);
        bus_wr(2, 0); check("R9 cleared", irq, 0);
        bus_wr(3, 0);

        // R2 other divisors
        bus_wr(4, 4); cur_div = 4;
        send_char(8'hA7, 1'b1);
        bus_rd(0, 1, d, dn); check("R2 div4", d, 8'hA7);
        bus_wr(4, 16); cur_div = 16;
        send_char(8'h3C, 1'b1);
        bus_rd(0, 1, d, dn); check("R2 div16", d, 8'h3C);
        check("R3 final avail", avail, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule